// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Access Rights

This block caches recent virtual-to-physical page translations for a processor's memory pipeline. Every stored entry is compared against the incoming virtual page number and the current address-space number in the same cycle. A registered result follows one cycle after the request. It carries a hit flag, the translated physical address and a protection fault flag. Pages are 8 KB, so the 13 low address bits pass from the virtual address to the physical address unchanged.

Each entry is tagged with an address-space number. Translations of different processes can therefore live side by side, and a context switch needs no flush. Miss-handling software installs entries through a single-cycle fill strobe. A fill for a key that is already present replaces that entry. A new key goes into the slot named by a round-robin pointer. A flush strobe empties the whole buffer and is meant for the moment address-space numbers are recycled.

The lookup side is a valid/ready stream. The block accepts a request on every cycle, so `lk_ready` stays high and there is no back-pressure. The response has no ready. `rsp_valid` pulses for one cycle exactly one cycle after each accepted request, and the consumer must take it then. Fill and flush are plain strobes.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is low and every lookup misses.
- R2: A lookup whose virtual page number and address-space number match a valid entry, and which the entry permits, returns `rsp_hit`=1, `rsp_fault`=0 and `rsp_pa` = {entry physical page number, low 13 bits of `lk_va`}, in the cycle after acceptance.
- R3: A lookup that matches no valid entry, on either the page number or the address-space number, returns `rsp_hit`=0, `rsp_fault`=0 and `rsp_pa`=0.
- R4: Entries with the same virtual page number but different address-space numbers coexist, and each lookup returns the entry of its own address-space number.
- R5: The fill permission field is 4 bits: bit0 kernel read, bit1 user read, bit2 kernel write, bit3 user write. A hit checks the bit at index {`lk_write`,`lk_user`}. When that bit is 0, the result is `rsp_hit`=1, `rsp_fault`=1 and `rsp_pa`=0.
- R6: A fill with a new key writes the slot under the round-robin pointer, and the pointer then moves to the next slot, wrapping after slot 15. With 16 entries full, the next new key evicts the oldest new-key fill.
- R7: A fill whose key is already present overwrites that entry in place. This includes its physical page number and permissions. No duplicate is created and the pointer does not move.
- R8: A flush invalidates all entries and returns the round-robin pointer to slot 0.
- R9: A flush and a fill in the same cycle: the flush wins and the fill is discarded.
- R10: A lookup in the same cycle as a fill or flush sees the contents from before that cycle.
- R11: `lk_ready` is always 1. `rsp_valid` is high in exactly the cycle after each cycle with `lk_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready (always 1) |
| lk_va | input | 43 | Virtual address (page number in bits 42:13) |
| lk_asn | input | 8 | Current address-space number |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user mode, 0 = kernel mode |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Matching valid entry found |
| rsp_fault | output | 1 | Hit without the required permission |
| rsp_pa | output | 41 | Physical address, 0 on miss or fault |
| fill_valid | input | 1 | Install-entry strobe |
| fill_vpn | input | 30 | Virtual page number to install |
| fill_asn | input | 8 | Address-space number to install |
| fill_ppn | input | 28 | Physical page number to install |
| fill_perm | input | 4 | Permission bits (see R5) |
| flush_all | input | 1 | Invalidate every entry |

## Verification
A stale valid bit shows up as a hit with a stale physical page on the very next lookup of that key. A wrong round-robin pointer stays hidden until the buffer is full. It then appears as the wrong key missing after the seventeenth new fill following a flush. A duplicate entry left by a refill shows up as the old page number on the next lookup of that key. Permission decode errors show up in the cycle after a single lookup as a spurious or missing fault, so each of the four access kinds is driven against single-bit permission masks.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Permission bits, indexed by {write, user}
  typedef struct packed {
    logic usr_wr;
    logic krn_wr;
    logic usr_rd;
    logic krn_rd;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8
) (
  input  logic [ENTRIES-1:0]            ent_valid,
  input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
  input  logic [ENTRIES-1:0][ASN_W-1:0] ent_asn,
  input  logic [VPN_W-1:0]              key_vpn,
  input  logic [ASN_W-1:0]              key_asn,
  output logic [ENTRIES-1:0]            match
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_vpn[i] == key_vpn) && (ent_asn[i] == key_asn);
  end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  tlb_perm_t perm,
  input  logic      is_write,
  input  logic      is_user,
  output logic      allow
);
  logic [3:0] bits;
  assign bits  = perm;
  assign allow = bits[{is_write, is_user}];
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (clear)   ptr <= '0;
    else if (advance) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PPN_W   = 28,
  parameter int OFS_W   = 13,
  localparam int VA_W   = VPN_W + OFS_W,
  localparam int PA_W   = PPN_W + OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [VA_W-1:0]  lk_va,
  input  logic [ASN_W-1:0] lk_asn,
  input  logic             lk_write,
  input  logic             lk_user,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_perm,
  input  logic             flush_all
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][ASN_W-1:0] asn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  tlb_perm_t [ENTRIES-1:0]       perm_q;

  logic [ENTRIES-1:0] lk_hitv;
  logic [ENTRIES-1:0] fl_hitv;
  logic [IDX_W-1:0]   rr_ptr;
  logic               fill_en;
  logic               fill_dup;
  logic               lk_any;
  logic [PPN_W-1:0]   sel_ppn;
  tlb_perm_t          sel_perm;
  logic               sel_allow;
  logic [VPN_W-1:0]   lk_vpn;

  assign lk_ready = 1'b1;
  assign lk_vpn   = lk_va[VA_W-1:OFS_W];

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam_lk (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asn(asn_q),
    .key_vpn(lk_vpn), .key_asn(lk_asn), .match(lk_hitv)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_cam_fill (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asn(asn_q),
    .key_vpn(fill_vpn), .key_asn(fill_asn), .match(fl_hitv)
  );

  // Keys are unique, so an AND-OR mux selects the single matching entry
  always_comb begin
    sel_ppn  = '0;
    sel_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hitv[i]) begin
        sel_ppn  = sel_ppn | ppn_q[i];
        sel_perm = sel_perm | perm_q[i];
      end
    end
  end

  assign lk_any = |lk_hitv;

  tlb_perm_chk u_perm (
    .perm(sel_perm), .is_write(lk_write), .is_user(lk_user), .allow(sel_allow)
  );

  assign fill_en  = fill_valid && !flush_all;
  assign fill_dup = |fl_hitv;

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .clear(flush_all),
    .advance(fill_en && !fill_dup), .ptr(rr_ptr)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic wr_here;
    assign wr_here = fill_en && (fill_dup ? fl_hitv[i] : (rr_ptr == IDX_W'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         valid_q[i] <= 1'b0;
      else if (flush_all) valid_q[i] <= 1'b0;
      else if (wr_here)   valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_here) begin
        vpn_q[i]  <= fill_vpn;
        asn_q[i]  <= fill_asn;
        ppn_q[i]  <= fill_ppn;
        perm_q[i] <= tlb_perm_t'(fill_perm);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && lk_any;
      rsp_fault <= lk_valid && lk_any && !sel_allow;
      rsp_pa    <= (lk_valid && lk_any && sel_allow) ? {sel_ppn, lk_va[OFS_W-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int PA_W    = 41
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               flush_all,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_pa,
  input logic [ENTRIES-1:0] lk_hitv,
  input logic [ENTRIES-1:0] valid_q
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid); // R11
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R11
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_fault && rsp_pa == '0)); // R3
  AST_FAULT_BLANKS_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_pa == '0)); // R5
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv)); // R7
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0)); // R8
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (.*);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
  localparam int VPN_W = 30, ASN_W = 8, PPN_W = 28, OFS_W = 13;
  localparam int VA_W = VPN_W + OFS_W, PA_W = PPN_W + OFS_W;
  localparam logic [OFS_W-1:0] OFS = 13'h1A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [VA_W-1:0] lk_va = '0;
  logic [ASN_W-1:0] lk_asn = '0;
  logic lk_ready, rsp_valid, rsp_hit, rsp_fault;
  logic [PA_W-1:0] rsp_pa;
  logic fill_valid = 1'b0, flush_all = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [ASN_W-1:0] fill_asn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [3:0] fill_perm = '0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tlb_fa u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_va(lk_va), .lk_asn(lk_asn), .lk_write(lk_write), .lk_user(lk_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush_all(flush_all)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                      input logic [PPN_W-1:0] ppn, input logic [3:0] perm);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_asn = asn; fill_ppn = ppn; fill_perm = perm;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  // Issue one lookup and compare the registered response
  task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                      input logic w, input logic u, input logic exp_hit,
                      input logic exp_fault, input logic [PPN_W-1:0] exp_ppn, input string req);
    logic [PA_W-1:0] exp_pa;
    @(negedge clk);
    lk_valid = 1'b1; lk_va = {vpn, OFS}; lk_asn = asn; lk_write = w; lk_user = u;
    @(posedge clk); #1;
    exp_pa = (exp_hit && !exp_fault) ? {exp_ppn, OFS} : '0;
    check(rsp_valid == 1'b1, {req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check(rsp_hit == exp_hit, {req, " hit"}, 64'(rsp_hit), 64'(exp_hit));
    check(rsp_fault == exp_fault, {req, " fault"}, 64'(rsp_fault), 64'(exp_fault));
    check(rsp_pa == exp_pa, {req, " pa"}, 64'(rsp_pa), 64'(exp_pa));
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(lk_ready == 1'b1, "R11 lk_ready", 64'(lk_ready), 64'd1);
    look(30'h5, 8'h1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R1 empty lookup");
    @(posedge clk); #1;
    check(rsp_valid == 1'b0, "R11 rsp_valid pulse only", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_basic();
    fill(30'h100, 8'h3, 28'hABC, 4'hF);
    look(30'h100, 8'h3, 1'b0, 1'b1, 1'b1, 1'b0, 28'hABC, "R2 hit");
    look(30'h100, 8'h3, 1'b1, 1'b0, 1'b1, 1'b0, 28'hABC, "R2 hit kernel write");
  endtask

  task automatic t_miss();
    look(30'h101, 8'h3, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 vpn mismatch");
    look(30'h100, 8'h9, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3 asn mismatch");
  endtask

  task automatic t_asn();
    fill(30'h100, 8'h4, 28'h555, 4'hF);
    look(30'h100, 8'h3, 1'b0, 1'b0, 1'b1, 1'b0, 28'hABC, "R4 asn3");
    look(30'h100, 8'h4, 1'b0, 1'b0, 1'b1, 1'b0, 28'h555, "R4 asn4");
  endtask

  task automatic t_perm();
    fill(30'h200, 8'h1, 28'h77, 4'b0001);
    look(30'h200, 8'h1, 1'b0, 1'b0, 1'b1, 1'b0, 28'h77, "R5 kernel read ok");
    look(30'h200, 8'h1, 1'b0, 1'b1, 1'b1, 1'b1, 28'h77, "R5 user read fault");
    look(30'h200, 8'h1, 1'b1, 1'b0, 1'b1, 1'b1, 28'h77, "R5 kernel write fault");
    look(30'h200, 8'h1, 1'b1, 1'b1, 1'b1, 1'b1, 28'h77, "R5 user write fault");
    fill(30'h200, 8'h1, 28'h78, 4'b1000);
    look(30'h200, 8'h1, 1'b1, 1'b1, 1'b1, 1'b0, 28'h78, "R5 user write ok");
    look(30'h200, 8'h1, 1'b0, 1'b0, 1'b1, 1'b1, 28'h78, "R5 kernel read fault");
    fill(30'h200, 8'h1, 28'h79, 4'b0010);
    look(30'h200, 8'h1, 1'b0, 1'b1, 1'b1, 1'b0, 28'h79, "R5 user read ok");
    fill(30'h200, 8'h1, 28'h7A, 4'b0100);
    look(30'h200, 8'h1, 1'b1, 1'b0, 1'b1, 1'b0, 28'h7A, "R5 kernel write ok");
  endtask

  task automatic t_overwrite();
    fill(30'h300, 8'h2, 28'h11, 4'hF);
    fill(30'h300, 8'h2, 28'h22, 4'hF);
    look(30'h300, 8'h2, 1'b0, 1'b0, 1'b1, 1'b0, 28'h22, "R7 overwrite in place");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 30'h400; fill_asn = 8'h6; fill_ppn = 28'h44; fill_perm = 4'hF;
    lk_valid = 1'b1; lk_va = {30'h400, OFS}; lk_asn = 8'h6; lk_write = 1'b0; lk_user = 1'b0;
    @(posedge clk); #1;
    check(rsp_hit == 1'b0, "R10 lookup during fill sees old", 64'(rsp_hit), 64'd0);
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    look(30'h400, 8'h6, 1'b0, 1'b0, 1'b1, 1'b0, 28'h44, "R10 after fill");
  endtask

  task automatic t_flush_rr();
    flush();
    look(30'h100, 8'h3, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 flushed A");
    look(30'h300, 8'h2, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 flushed B");
    for (int i = 0; i < 16; i++) fill(30'h500 + 30'(i), 8'h7, 28'h900 + 28'(i), 4'hF);
    for (int i = 0; i < 16; i++)
      look(30'h500 + 30'(i), 8'h7, 1'b0, 1'b0, 1'b1, 1'b0, 28'h900 + 28'(i), "R6 full set");
    fill(30'h600, 8'h7, 28'hA00, 4'hF);
    look(30'h500, 8'h7, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R8 pointer reset evicts slot0");
    look(30'h501, 8'h7, 1'b0, 1'b0, 1'b1, 1'b0, 28'h901, "R6 slot1 kept");
    look(30'h600, 8'h7, 1'b0, 1'b0, 1'b1, 1'b0, 28'hA00, "R6 new entry");
    fill(30'h601, 8'h7, 28'hA01, 4'hF);
    look(30'h501, 8'h7, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R6 next victim slot1");
    look(30'h502, 8'h7, 1'b0, 1'b0, 1'b1, 1'b0, 28'h902, "R6 slot2 kept");
  endtask

  task automatic t_flush_fill();
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 30'h700; fill_asn = 8'h1; fill_ppn = 28'h70; fill_perm = 4'hF;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(30'h700, 8'h1, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 fill dropped by flush");
    look(30'h600, 8'h7, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R9 flush applied");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_miss();
    t_asn();
    t_perm();
    t_overwrite();
    t_same_cycle();
    t_flush_rr();
    t_flush_fill();
    finish_run();
  end
endmodule